// File: doc/BRIEF.md
# CAN Bus-Off Recovery Controller

This block follows a CAN node through the bus-off state and decides when it may rejoin the bus. The error-counter logic sends a one-cycle entry pulse when the node goes bus-off. From then on the block watches the sampled bus level on every bit-time strobe and counts runs of eleven consecutive recessive bits. When enough such runs have been seen, it releases the node. The error counters must be cleared outside this block once that release is reported.

Software can keep the node in bus-off through a hold bit. That bit is captured only at the moment of bus-off entry. If the captured value was clear, the recovery runs automatically, whatever software does afterwards. If it was set, software releases the node by clearing the bit. A release before the full group count has been reached lets the automatic recovery carry on. A release after the full count has been reached makes the node wait for one more eleven-bit recessive run.

The block runs on the system clock. Bus samples count only on cycles where the bit strobe is high.

Top module: `can_busoff_recovery`

## Requirements
- R1: After synchronous reset, `busoff` is 0, `recov_done` is 0 and `grp_cnt` is 0.
- R2: A cycle with `busoff_enter` high sets `busoff` to 1 and clears `grp_cnt` and the run counter from the next cycle on. It also captures `hold_sw` as the hold setting for this bus-off episode.
- R3: While counting, `bus_rx` = 1 means recessive and `bus_rx` = 0 means dominant. Each run of 11 consecutive recessive samples raises `grp_cnt` by one. A dominant sample before the run is complete restarts the run and leaves `grp_cnt` unchanged.
- R4: On cycles where `bit_tick` is 0, the value of `bus_rx` is ignored and the counters do not change.
- R5: If the captured hold setting is 0, the strobe that completes group 128 ends bus-off. In the next cycle `busoff` is 0 and `recov_done` is 1.
- R6: If the captured hold setting is 1 and `hold_sw` stays 1, `grp_cnt` saturates at 128 and the node stays in bus-off with no `recov_done`.
- R7: If `hold_sw` is cleared while the captured hold is set and `grp_cnt` is below 128, recovery finishes at group 128 as in R5, even if `hold_sw` is set again in the meantime.
- R8: If `hold_sw` is cleared after 128 groups have been counted under a set hold, the node leaves bus-off on the strobe that completes a further run of 11 consecutive recessive samples. A dominant sample restarts this run.
- R9: Setting `hold_sw` during a bus-off that began with the hold clear has no effect on that recovery.
- R10: `recov_done` lasts exactly one cycle. `grp_cnt` keeps its final value until the next bus-off entry.
- R11: A `busoff_enter` pulse during bus-off restarts the recovery: both counters are cleared and the hold setting is captured again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| busoff_enter | input | 1 | One-cycle pulse: the node has entered bus-off |
| bit_tick | input | 1 | Bit-time strobe; `bus_rx` is used only when this is high |
| bus_rx | input | 1 | Sampled bus level, 1 = recessive, 0 = dominant |
| hold_sw | input | 1 | Software bit; when captured as 1, it disables automatic recovery |
| busoff | output | 1 | High while the node is in bus-off |
| recov_done | output | 1 | One-cycle pulse when bus-off ends |
| grp_cnt | output | 8 | Number of 11-bit recessive groups counted, saturating at 128 |

## Verification
All state lives in registers updated on the clock edge where the strobe or pulse is sampled. So `busoff`, `grp_cnt` and `recov_done` each change exactly one cycle after the cycle that carries the stimulus. A software release of a held node takes effect on the first clock edge that sees `hold_sw` low. The bench drives each stimulus for one cycle from a falling edge and reads the outputs at the following falling edge, which is the first point where the result is due. The one-cycle pulse is then re-read one cycle later to confirm that it has gone. A counter of pulses, sampled on falling edges, confirms that held episodes produce none.

// File: rtl/can_busoff_recovery.sv
module can_busoff_recovery #(
  parameter int RUN_LEN = 11,
  parameter int GROUPS  = 128
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         busoff_enter,
  input  logic                         bit_tick,
  input  logic                         bus_rx,
  input  logic                         hold_sw,
  output logic                         busoff,
  output logic                         recov_done,
  output logic [$clog2(GROUPS+1)-1:0]  grp_cnt
);
  localparam int RUN_W = $clog2(RUN_LEN);
  localparam int GRP_W = $clog2(GROUPS + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);
  localparam logic [GRP_W-1:0] GRP_LAST = GRP_W'(GROUPS - 1);

  typedef enum logic [1:0] {ST_ACTIVE, ST_COUNT, ST_HELD, ST_RESYNC} st_t;

  st_t              st_q;
  logic [RUN_W-1:0] run_q;
  logic [GRP_W-1:0] grp_q;
  logic             hold_lat_q;
  logic             done_q;

  wire run_full = bit_tick && bus_rx && (run_q == RUN_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_ACTIVE;
      run_q      <= '0;
      grp_q      <= '0;
      hold_lat_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (busoff_enter) begin
        st_q       <= ST_COUNT;
        run_q      <= '0;
        grp_q      <= '0;
        hold_lat_q <= hold_sw;
      end else begin
        case (st_q)
          ST_COUNT: begin
            if (hold_lat_q && !hold_sw)
              hold_lat_q <= 1'b0;
            if (bit_tick) begin
              if (!bus_rx)
                run_q <= '0;
              else if (run_full) begin
                run_q <= '0;
                grp_q <= grp_q + 1'b1;
                if (grp_q == GRP_LAST) begin
                  if (!hold_lat_q || !hold_sw) begin
                    st_q   <= ST_ACTIVE;
                    done_q <= 1'b1;
                  end else
                    st_q <= ST_HELD;
                end
              end else
                run_q <= run_q + 1'b1;
            end
          end
          ST_HELD: begin
            if (!hold_sw) begin
              st_q  <= ST_RESYNC;
              run_q <= '0;
            end
          end
          ST_RESYNC: begin
            if (bit_tick) begin
              if (!bus_rx)
                run_q <= '0;
              else if (run_full) begin
                run_q  <= '0;
                st_q   <= ST_ACTIVE;
                done_q <= 1'b1;
              end else
                run_q <= run_q + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign busoff     = (st_q != ST_ACTIVE);
  assign recov_done = done_q;
  assign grp_cnt    = grp_q;
endmodule

// File: rtl/can_busoff_recovery_chk.sv
module can_busoff_recovery_chk #(
  parameter int GROUPS = 128
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        busoff_enter,
  input logic                        bit_tick,
  input logic                        busoff,
  input logic                        recov_done,
  input logic [$clog2(GROUPS+1)-1:0] grp_cnt
);
  AST_ENTER_CLEARS: assert property (@(posedge clk) disable iff (rst)
    busoff_enter |=> busoff && grp_cnt == '0); // R2

  AST_GRP_STEP: assert property (@(posedge clk) disable iff (rst)
    !busoff_enter |=> (grp_cnt == $past(grp_cnt)) || (grp_cnt == $past(grp_cnt) + 1'b1)); // R3

  AST_NO_TICK_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
    !bit_tick && !busoff_enter |=> $stable(grp_cnt)); // R4

  AST_DONE_LEAVES: assert property (@(posedge clk) disable iff (rst)
    recov_done |-> !busoff && $past(busoff)); // R5

  AST_GRP_SATURATE: assert property (@(posedge clk) disable iff (rst)
    grp_cnt <= GROUPS); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    recov_done |=> !recov_done); // R10
endmodule

bind can_busoff_recovery can_busoff_recovery_chk #(.GROUPS(GROUPS)) u_chk (
  .clk(clk), .rst(rst), .busoff_enter(busoff_enter), .bit_tick(bit_tick),
  .busoff(busoff), .recov_done(recov_done), .grp_cnt(grp_cnt)
);

// File: tb/can_busoff_recovery_tb.sv
module can_busoff_recovery_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RUN_LEN = 11;
  localparam int GROUPS  = 128;

  logic clk = 0, rst = 1, busoff_enter = 0, bit_tick = 0, bus_rx = 1, hold_sw = 0;
  logic busoff, recov_done;
  logic [7:0] grp_cnt;
  int checks = 0, errors = 0, done_seen = 0;

  can_busoff_recovery #(.RUN_LEN(RUN_LEN), .GROUPS(GROUPS)) u_dut (
    .clk(clk), .rst(rst), .busoff_enter(busoff_enter), .bit_tick(bit_tick),
    .bus_rx(bus_rx), .hold_sw(hold_sw), .busoff(busoff),
    .recov_done(recov_done), .grp_cnt(grp_cnt));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) if (recov_done) done_seen++;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(logic rx);
    @(negedge clk); bit_tick = 1; bus_rx = rx;
    @(negedge clk); bit_tick = 0;
  endtask

  task automatic groups(int n);
    for (int i = 0; i < n * RUN_LEN; i++) tick(1);
  endtask

  task automatic enter(logic hold);
    @(negedge clk); busoff_enter = 1; hold_sw = hold;
    @(negedge clk); busoff_enter = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; hold_sw = 0;
    @(negedge clk); rst = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 busoff", busoff, 0);
    chk("R1 done", recov_done, 0);
    chk("R1 grp", grp_cnt, 0);
  endtask

  task automatic t_runs();
    enter(0);
    chk("R2 busoff", busoff, 1);
    chk("R2 grp", grp_cnt, 0);
    for (int i = 0; i < RUN_LEN - 1; i++) tick(1);
    tick(0);
    chk("R3 dominant restarts run", grp_cnt, 0);
    groups(1);
    chk("R3 one group", grp_cnt, 1);
    for (int i = 0; i < 5; i++) tick(1);
    bus_rx = 0;
    repeat (3) @(negedge clk);
    chk("R4 no tick holds grp", grp_cnt, 1);
    for (int i = 0; i < RUN_LEN - 5; i++) tick(1);
    chk("R4 run survived untimed dominant", grp_cnt, 2);
    enter(1);
    chk("R11 grp cleared", grp_cnt, 0);
    chk("R11 still busoff", busoff, 1);
    do_reset();
  endtask

  task automatic t_auto();
    enter(0);
    @(negedge clk); hold_sw = 1;
    groups(GROUPS - 1);
    for (int i = 0; i < RUN_LEN - 1; i++) tick(1);
    chk("R5 before last bit", busoff, 1);
    chk("R9 no early done", done_seen, 0);
    tick(1);
    chk("R5 busoff dropped", busoff, 0);
    chk("R5 done pulse", recov_done, 1);
    chk("R10 grp final", grp_cnt, GROUPS);
    @(negedge clk);
    chk("R10 pulse one cycle", recov_done, 0);
    chk("R10 grp held", grp_cnt, GROUPS);
    done_seen = 0;
    do_reset();
  endtask

  task automatic t_hold();
    enter(1);
    groups(GROUPS + 2);
    chk("R6 grp saturates", grp_cnt, GROUPS);
    chk("R6 still busoff", busoff, 1);
    chk("R6 no done", done_seen, 0);
    @(negedge clk); hold_sw = 0;
    @(negedge clk);
    chk("R8 release waits", busoff, 1);
    for (int i = 0; i < 5; i++) tick(1);
    tick(0);
    for (int i = 0; i < RUN_LEN - 1; i++) tick(1);
    chk("R8 dominant restarts run", busoff, 1);
    tick(1);
    chk("R8 busoff dropped", busoff, 0);
    chk("R8 done pulse", recov_done, 1);
    done_seen = 0;
    do_reset();
  endtask

  task automatic t_early();
    enter(1);
    groups(50);
    @(negedge clk); hold_sw = 0;
    @(negedge clk); hold_sw = 1;
    groups(GROUPS - 51);
    for (int i = 0; i < RUN_LEN - 1; i++) tick(1);
    chk("R7 not yet", busoff, 1);
    tick(1);
    chk("R7 busoff dropped", busoff, 0);
    chk("R7 done pulse", recov_done, 1);
    done_seen = 0;
    do_reset();
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_runs();
    t_auto();
    t_hold();
    t_early();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule